// File: doc/BRIEF.md
# Self-Timed Flash Byte Programmer

This block sits between a parallel programming port and a small nonvolatile byte array. The array is modelled here with ordinary registers. The caller presents an address, a data byte and an operation select, then raises a one-cycle program strobe. The operation select chooses between programming one byte and erasing the whole array. The controller latches the request and holds itself busy for a fixed, parameterised number of clock cycles. At the end of that time it commits the result to the array.

While an operation runs, the caller can watch progress in two ways. The first is a ready output. The second is a polled read: reading the address being programmed returns the inverse of the written bit 7 on data bit 7 until the write lands. Programming can only clear bits, so a byte that is not blank (0xFF) can only return to a fully writable state through a chip erase. An attempt to program such a byte raises a sticky error flag.

Top module: `flash_byte_prog`

## Requirements
- R1: After reset every location reads 0xFF, `ready` is 1 and `errSticky` is 0.
- R2: A byte program stores the bitwise AND of the previous contents and the new data, so bits only go from 1 to 0.
- R3: A program strobe accepted while `ready` is 1 makes `ready` 0 from the next cycle on. `ready` stays 0 for exactly PROG_CYCLES clock cycles, and the new contents are readable when `ready` returns to 1.
- R4: While a byte program is busy, reading the latched address returns the inverse of the written bit 7 on bit 7. Bits 6..0 return the contents held before the write.
- R5: While a byte program is busy, reading any other address returns its true stored value.
- R6: A strobe that arrives while the block is busy is ignored. Its address, data and operation select have no effect, and the running operation's timing is unchanged. Inputs `addrIn`, `dataIn` and `modeErase` are sampled only at the accepting edge.
- R7: A strobe with `modeErase`=1 starts a chip erase. `ready` stays 0 for exactly ERASE_CYCLES cycles, bit 7 reads 0 at every address during the erase, and every location reads 0xFF afterwards.
- R8: Programming a location whose contents are not 0xFF sets `errSticky`. The flag stays set through later programs and erases and clears only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progStrobe | input | 1 | Start pulse for an operation |
| modeErase | input | 1 | 1 = chip erase, 0 = byte program |
| addrIn | input | ADDR_W | Byte address to program |
| dataIn | input | 8 | Byte value to program |
| readAddr | input | ADDR_W | Address for the combinational read port |
| readData | output | 8 | Read/poll data |
| ready | output | 1 | 1 when idle and able to accept a strobe |
| errSticky | output | 1 | Set on a program to a non-blank byte |

## Verification
A wrong cycle count or a broken state transition shows up on `ready`. It returns one cycle early or late, so the bench counts the busy cycles exactly for both operations. A lost or misdirected commit shows up on the read port in the first cycle after `ready` rises. A bad poll path shows up on bit 7 in the first cycle after the strobe is accepted. A strobe that wrongly leaks through while busy shows up in one of three places: a changed busy length, an erased array, or a wrong stored byte.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2
  } fbpState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latch;        // capture address/data of a byte program
    logic commitProg;   // land the AND-merged byte
    logic commitErase;  // blank the whole array
    logic pollProg;     // byte program in flight
    logic pollErase;    // chip erase in flight
  } ctlStrobes_t;
endpackage

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
  import fbp_pkg::*;
#(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        progStrobe,
  input  logic        modeErase,
  output ctlStrobes_t strobes,
  output logic        ready
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

  fbpState_t state;
  logic [CW-1:0] cnt;
  logic accept, lastTick;

  assign accept   = (state == ST_IDLE) && progStrobe;
  assign lastTick = (state != ST_IDLE) && (cnt == '0);
  assign ready    = (state == ST_IDLE);

  always_comb begin
    strobes             = '0;
    strobes.latch       = accept && !modeErase;
    strobes.commitProg  = lastTick && (state == ST_PROG);
    strobes.commitErase = lastTick && (state == ST_ERASE);
    strobes.pollProg    = (state == ST_PROG);
    strobes.pollErase   = (state == ST_ERASE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (accept) begin
      state <= modeErase ? ST_ERASE : ST_PROG;
      cnt   <= modeErase ? ERASE_LOAD : PROG_LOAD;
    end else if (state != ST_IDLE) begin
      if (cnt == '0) state <= ST_IDLE;
      else           cnt   <= cnt - CW'(1);
    end
  end

  // R3: an accepted strobe drops ready on the next cycle
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (ready && progStrobe) |=> !ready);
  // R3: busy counter walks down one per cycle
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
  // R6: strobes during busy do not disturb the running operation
  a_r6_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && progStrobe && cnt != '0) |=> $stable(state));
  // R7: erase select leads to the erase state
  a_r7_erase_mode: assert property (@(posedge clk) disable iff (!rstN)
    (ready && progStrobe && modeErase) |=> strobes.pollErase);
endmodule

// File: rtl/fbp_array.sv
module fbp_array
  import fbp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic [ADDR_W-1:0] readAddr,
  output logic [7:0]        readData,
  output logic              errSticky
);
  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] lastAddr;
  logic [7:0]        lastData;
  logic [7:0]        rawRead;
  logic              allBlank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      lastAddr  <= '0;
      lastData  <= 8'hFF;
      errSticky <= 1'b0;
    end else begin
      if (strobes.latch) begin
        lastAddr <= addrIn;
        lastData <= dataIn;
        if (mem[addrIn] != 8'hFF) errSticky <= 1'b1;
      end
      if (strobes.commitErase) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (strobes.commitProg) begin
        mem[lastAddr] <= mem[lastAddr] & lastData;
      end
    end
  end

  assign rawRead = mem[readAddr];

  always_comb begin
    if (strobes.pollErase)
      readData = {1'b0, rawRead[6:0]};
    else if (strobes.pollProg && (readAddr == lastAddr))
      readData = {~lastData[7], rawRead[6:0]};
    else
      readData = rawRead;
  end

  always_comb begin
    allBlank = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] != 8'hFF) allBlank = 1'b0;
  end

  // R2: a commit only clears bits and never sets one absent from the data
  a_r2_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitProg |=> (((mem[lastAddr] & ~$past(mem[lastAddr])) == 8'h00) &&
                            ((mem[lastAddr] & ~$past(lastData)) == 8'h00)));
  // R6: request held steady while the program is in flight
  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pollProg && !strobes.commitProg) |=> ($stable(lastAddr) && $stable(lastData)));
  // R7: erase leaves every location blank
  a_r7_erase_blank: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitErase |=> allBlank);
  // R8: error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);
endmodule

// File: rtl/flash_byte_prog.sv
module flash_byte_prog
  import fbp_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20,
  parameter int ADDR_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progStrobe,
  input  logic              modeErase,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic [ADDR_W-1:0] readAddr,
  output logic [7:0]        readData,
  output logic              ready,
  output logic              errSticky
);
  ctlStrobes_t strobes;

  fbp_ctrl #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .progStrobe(progStrobe), .modeErase(modeErase),
    .strobes(strobes), .ready(ready)
  );

  fbp_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrIn(addrIn), .dataIn(dataIn),
    .readAddr(readAddr), .readData(readData), .errSticky(errSticky)
  );
endmodule

// File: tb/flash_byte_prog_test.sv
`timescale 1ns/1ps
module flash_byte_prog_test;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int PROG  = 8;
  localparam int ERASE = 20;
  localparam int NVEC  = 6;

  // {addr[3:0], data[7:0], expected stored[7:0], expected err}
  localparam logic [20:0] VEC [NVEC] = '{
    {4'd3,  8'h5A, 8'h5A, 1'b0},
    {4'd7,  8'h80, 8'h80, 1'b0},
    {4'd15, 8'h00, 8'h00, 1'b0},
    {4'd0,  8'hFF, 8'hFF, 1'b0},
    {4'd3,  8'hF0, 8'h50, 1'b1},
    {4'd0,  8'h7E, 8'h7E, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progStrobe = 1'b0;
  logic modeErase = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic [AW-1:0] readAddr = '0;
  logic [7:0] readData;
  logic ready, errSticky;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  flash_byte_prog #(.DEPTH(DEPTH), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) uut (
    .clk(clk), .rstN(rstN), .progStrobe(progStrobe), .modeErase(modeErase),
    .addrIn(addrIn), .dataIn(dataIn), .readAddr(readAddr), .readData(readData),
    .ready(ready), .errSticky(errSticky)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue strobe; returns at the negedge following the accepting edge
  task automatic startOp(input logic [AW-1:0] a, input logic [7:0] d, input logic er);
    @(negedge clk);
    addrIn = a; dataIn = d; modeErase = er; progStrobe = 1'b1;
    @(negedge clk);
    progStrobe = 1'b0;
  endtask

  task automatic countBusy(output int n);
    n = 0;
    while (!ready && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic checkAllBlank(input string req);
    bit ok = 1;
    logic [7:0] bad = 8'hFF;
    for (int i = 0; i < DEPTH; i++) begin
      readAddr = AW'(i);
      #1;
      if (readData != 8'hFF) begin ok = 0; bad = readData; end
    end
    chk(ok, req, bad, 8'hFF);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(errSticky == 1'b0, "R1 err", errSticky, 0);
    checkAllBlank("R1 blank");

    // Vector walk: R2 R3 R4 R5 R8
    for (int v = 0; v < NVEC; v++) begin
      logic [AW-1:0] a;
      logic [7:0] d, st;
      logic e;
      {a, d, st, e} = VEC[v];
      readAddr = a;
      startOp(a, d, 1'b0);
      #1;
      chk(ready == 1'b0, "R3 busy", ready, 0);
      chk(readData == {~d[7], model[a][6:0]}, "R4 poll", readData, {~d[7], model[a][6:0]});
      readAddr = a ^ AW'(1);
      #1;
      chk(readData == model[a ^ AW'(1)], "R5 other", readData, model[a ^ AW'(1)]);
      repeat (PROG - 1) @(negedge clk);
      chk(ready == 1'b0, "R3 still busy", ready, 0);
      @(negedge clk);
      chk(ready == 1'b1, "R3 ready", ready, 1);
      model[a] = model[a] & d;
      readAddr = a;
      #1;
      chk(readData == st && st == model[a], "R2 stored", readData, st);
      chk(errSticky == e, "R8 err", errSticky, e);
    end

    // R6: strobe during busy ignored
    startOp(4'd9, 8'h11, 1'b0);
    addrIn = 4'd10; dataIn = 8'h22; modeErase = 1'b1; progStrobe = 1'b1;
    @(negedge clk);
    progStrobe = 1'b0; addrIn = 4'd11; dataIn = 8'h00; modeErase = 1'b0;
    countBusy(n);
    chk(n == PROG - 1, "R6 timing", n, PROG - 1);
    model[9] = 8'h11;
    readAddr = 4'd9; #1;
    chk(readData == 8'h11, "R6 first req kept", readData, 8'h11);
    readAddr = 4'd10; #1;
    chk(readData == 8'hFF, "R6 second req dropped", readData, 8'hFF);
    readAddr = 4'd3; #1;
    chk(readData == model[3], "R6 no erase", readData, model[3]);

    // R7 chip erase
    readAddr = 4'd5;
    startOp(4'd0, 8'h00, 1'b1);
    #1;
    chk(readData[7] == 1'b0, "R7 poll bit7", readData[7], 0);
    readAddr = 4'd3; #1;
    chk(readData[7] == 1'b0, "R7 poll any addr", readData[7], 0);
    countBusy(n);
    chk(n == ERASE, "R7 timing", n, ERASE);
    checkAllBlank("R7 blank");
    chk(errSticky == 1'b1, "R8 survives erase", errSticky, 1);

    // R2/R8 after erase: byte writable again, flag still set
    readAddr = 4'd3;
    startOp(4'd3, 8'h0F, 1'b0);
    countBusy(n);
    #1;
    chk(readData == 8'h0F, "R2 after erase", readData, 8'h0F);
    chk(errSticky == 1'b1, "R8 sticky", errSticky, 1);

    // R1/R8 reset clears
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(errSticky == 1'b0, "R8 reset clears", errSticky, 0);
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    checkAllBlank("R1 blank after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule